// File: doc/BRIEF.md
# Microsecond Timer with Compare Interrupt

This block keeps a free-running time count for a small processor. The counting logic runs on its own fixed-frequency timer clock, 10 MHz by default. A divider turns that clock into a one-microsecond step, so software gets a microsecond timestamp that does not depend on the processor clock frequency.

Software sets a compare value. The block raises an interrupt once the count reaches that value, and the interrupt stays raised until software writes a new compare value. The processor side sits entirely in the processor clock domain and has three parts: a compare write strobe with its data, a compare readback, and the synchronised count and interrupt outputs.

Two things cross between the unrelated clocks. The count crosses as a Gray-coded vector. Compare updates travel through a toggle request with a toggle acknowledge. While an update is still in flight, the interrupt from the old compare value is held off.

Top module: `usec_timer`

## Requirements
- R1: While `rst` is high, and on the first processor cycle after it falls, `now_us` reads 0, `irq` reads 0 and `cmp_rd` reads all ones.
- R2: The count advances by exactly one every DIV timer-clock periods (DIV = 10, giving 1 us at 10 MHz). Seen on `now_us`, two successive changes are 250 processor cycles apart (±1) with the 4 ns processor clock and the 100 ns timer clock.
- R3: From one processor cycle to the next, `now_us` either holds its value or grows by exactly one, modulo 2^CNT_W. A torn value is never visible.
- R4: The count wraps from all ones to zero.
- R5: `cmp_rd` returns the value written with `cmp_wr_en`, starting on the processor cycle after the write.
- R6: `irq` stays low while the count is below the compare value. It rises when the count equals the compare value.
- R7: Once raised, `irq` stays high after the count moves past the compare value, as long as no compare write happens.
- R8: A compare write pulls `irq` low on the next processor cycle. The old compare value cannot raise `irq` again after that write.
- R9: A new compare value is in force in the timer domain no more than four timer-clock cycles after the write. A value equal to the count at that moment raises `irq` before the count moves on.
- R10: When writes arrive on consecutive cycles, the last one wins for both `cmp_rd` and the matching. An intermediate value never raises `irq`.
- R11: After reset, with no write at all, `irq` rises when the count reaches all ones, because reset loads the compare value as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Active-high reset, synchronous to `clk`; resynchronised for the timer domain |
| tmr_clk | input | 1 | Fixed-frequency timer clock (10 MHz nominal) |
| cmp_wr_en | input | 1 | Compare write strobe, one `clk` cycle per write |
| cmp_wr_data | input | CNT_W | New compare value |
| cmp_rd | output | CNT_W | Last compare value written by software |
| now_us | output | CNT_W | Microsecond count, synchronised into the `clk` domain |
| irq | output | 1 | Compare interrupt, active high, held until the next compare write |

## Verification
Each result has a known delay.
- `cmp_rd` and the drop of `irq` after a write are due on the first `clk` edge after the write, so they are sampled one nanosecond after that edge.
- Count changes and a rising `irq` leave the timer domain one timer cycle after the count register moves, then pass through two `clk` flops.

For the second kind, the checks avoid sampling near a transition. They either wait for the observed event and then sample a few cycles later, or they sample about 100 processor cycles into a microsecond, where neither neighbouring count value can be in flight. The update bound of four timer cycles is tested by writing the current count just after an observed step: the interrupt must arrive before the count moves on, about ten timer cycles later.

// File: rtl/usec_tmr_pkg.sv
package usec_tmr_pkg;

    localparam int unsigned DEF_CNT_W = 32;
    localparam int unsigned DEF_DIV   = 10;
    localparam int unsigned DEF_SYNC  = 2;

    // Processor-side state of the compare update handshake
    typedef struct packed {
        logic tgl;    // request toggle sent to the timer domain
        logic dirty;  // a write is waiting for the current transfer to finish
    } upd_state_t;

    // Widths up to 64 bits; callers zero-extend, then truncate the result
    function automatic logic [63:0] to_gray(input logic [63:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [63:0] from_gray(input logic [63:0] g);
        logic [63:0] b;
        b[63] = g[63];
        for (int i = 62; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/tmr_sync_vec.sv
module tmr_sync_vec #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[gi] <= {W{RST_VAL}};
                else     st[gi] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[gi] <= {W{RST_VAL}};
                else     st[gi] <= st[gi-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned DIV = 10
) (
    input  logic tclk,
    input  logic trst,
    output logic tick
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge tclk) begin
        if (trst)      cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import usec_tmr_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         tclk,
    input  logic         trst,
    input  logic         tick,
    input  logic         req_s,     // synchronised request toggle
    input  logic [W-1:0] cmp_new,   // held stable while a request is open
    output logic [W-1:0] gray_q,
    output logic         hit,
    output logic         ack_tgl,
    output logic         seen_tgl
);
    logic [W-1:0] count;
    logic [W-1:0] cmp;
    logic         load;
    logic         load_d;

    assign load = req_s ^ seen_tgl;

    always_ff @(posedge tclk) begin
        if (trst) begin
            count    <= '0;
            cmp      <= '1;
            hit      <= 1'b0;
            seen_tgl <= 1'b0;
            load_d   <= 1'b0;
            ack_tgl  <= 1'b0;
            gray_q   <= '0;
        end else begin
            seen_tgl <= req_s;
            load_d   <= load;
            if (tick) count <= count + 1'b1;
            gray_q <= W'(to_gray(64'(count)));
            if (load) begin
                cmp <= cmp_new;
                hit <= 1'b0;
            end else if (count == cmp) begin
                hit <= 1'b1;
            end
            // acknowledge one cycle after the clear, so the cleared hit
            // reaches the other side before the acknowledge does
            if (load_d) ack_tgl <= ~ack_tgl;
        end
    end
endmodule

// File: rtl/tmr_cmp_port.sv
module tmr_cmp_port
    import usec_tmr_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ack_s,
    output logic [W-1:0] cmp_sw,
    output logic [W-1:0] cmp_xfer,
    output logic         req_tgl,
    output logic         mask
);
    upd_state_t st;
    logic       busy;
    logic       launch;

    assign busy    = st.tgl ^ ack_s;
    assign launch  = ~busy & (wr | st.dirty);
    assign req_tgl = st.tgl;
    assign mask    = busy | st.dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_sw   <= '1;
            cmp_xfer <= '1;
            st       <= '0;
        end else begin
            if (wr) cmp_sw <= wdata;
            if (launch) begin
                cmp_xfer <= wr ? wdata : cmp_sw;
                st.tgl   <= ~st.tgl;
                st.dirty <= 1'b0;
            end else if (wr) begin
                st.dirty <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/usec_timer.sv
module usec_timer
    import usec_tmr_pkg::*;
#(
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned DIV         = DEF_DIV,
    parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tmr_clk,
    input  logic             cmp_wr_en,
    input  logic [CNT_W-1:0] cmp_wr_data,
    output logic [CNT_W-1:0] cmp_rd,
    output logic [CNT_W-1:0] now_us,
    output logic             irq
);
    logic             t_rst;
    logic             tick;
    logic             req_s;
    logic             upd_req;
    logic             core_seen;
    logic             core_ack;
    logic             ack_s;
    logic             core_hit;
    logic             hit_s;
    logic             upd_mask;
    logic [CNT_W-1:0] cmp_xfer;
    logic [CNT_W-1:0] gray_t;
    logic [CNT_W-1:0] gray_s;

    // reset into the timer domain: asserts with rst, releases after the stages
    tmr_sync_vec #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
        .clk(tmr_clk), .rst(rst), .d(1'b0), .q(t_rst)
    );

    tmr_prescale #(.DIV(DIV)) u_pre (
        .tclk(tmr_clk), .trst(t_rst), .tick(tick)
    );

    tmr_sync_vec #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk(tmr_clk), .rst(t_rst), .d(upd_req), .q(req_s)
    );

    tmr_core #(.W(CNT_W)) u_core (
        .tclk(tmr_clk), .trst(t_rst), .tick(tick), .req_s(req_s),
        .cmp_new(cmp_xfer), .gray_q(gray_t), .hit(core_hit),
        .ack_tgl(core_ack), .seen_tgl(core_seen)
    );

    tmr_sync_vec #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst(rst), .d(core_ack), .q(ack_s)
    );

    tmr_sync_vec #(.W(1), .STAGES(SYNC_STAGES)) u_hit_sync (
        .clk(clk), .rst(rst), .d(core_hit), .q(hit_s)
    );

    tmr_sync_vec #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst(rst), .d(gray_t), .q(gray_s)
    );

    tmr_cmp_port #(.W(CNT_W)) u_port (
        .clk(clk), .rst(rst), .wr(cmp_wr_en), .wdata(cmp_wr_data),
        .ack_s(ack_s), .cmp_sw(cmp_rd), .cmp_xfer(cmp_xfer),
        .req_tgl(upd_req), .mask(upd_mask)
    );

    assign now_us = CNT_W'(from_gray(64'(gray_s)));
    assign irq    = hit_s & ~upd_mask;
endmodule

// File: rtl/usec_timer_chk.sv
module usec_timer_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         tmr_clk,
    input logic         trst,
    input logic         wr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] cmp_rd,
    input logic [W-1:0] now_us,
    input logic         irq,
    input logic         req_tgl,
    input logic         seen_tgl
);
    logic [7:0] lag;

    always_ff @(posedge tmr_clk) begin
        if (trst)                 lag <= '0;
        else if (req_tgl != seen_tgl) lag <= lag + 1'b1;
        else                      lag <= '0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (irq == 1'b0 && now_us == '0 && cmp_rd == '1));

    // R3
    no_tear_chk: assert property (@(posedge clk) disable iff (rst)
        (now_us == $past(now_us)) || (now_us == W'($past(now_us) + 1'b1)));

    // R5
    cmp_readback_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (cmp_rd == $past(wdata)));

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr) |=> irq);

    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> !irq);

    // R9
    upd_lag_chk: assert property (@(posedge tmr_clk) disable iff (trst)
        lag <= 8'd4);
endmodule

bind usec_timer usec_timer_chk #(.W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tmr_clk(tmr_clk), .trst(t_rst),
    .wr(cmp_wr_en), .wdata(cmp_wr_data), .cmp_rd(cmp_rd),
    .now_us(now_us), .irq(irq), .req_tgl(upd_req), .seen_tgl(core_seen)
);

// File: tb/sim_usec_timer.sv
module sim_usec_timer;
    logic        clk;
    logic        tmr_clk;
    logic        rst;
    logic        wr;
    logic [31:0] wdata;
    logic [31:0] cmp_rd;
    logic [31:0] now_us;
    logic        irq;
    logic [7:0]  s_cmp_rd;
    logic [7:0]  s_now;
    logic        s_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int tear0  = 0;
    int tear1  = 0;
    bit saw_wrap = 0;

    usec_timer u0 (
        .clk(clk), .rst(rst), .tmr_clk(tmr_clk), .cmp_wr_en(wr),
        .cmp_wr_data(wdata), .cmp_rd(cmp_rd), .now_us(now_us), .irq(irq)
    );

    usec_timer #(.CNT_W(8)) u1 (
        .clk(clk), .rst(rst), .tmr_clk(tmr_clk), .cmp_wr_en(1'b0),
        .cmp_wr_data(8'd0), .cmp_rd(s_cmp_rd), .now_us(s_now), .irq(s_irq)
    );

    initial begin
        clk = 1'b0;
        forever #2 clk = ~clk;
    end

    initial begin
        tmr_clk = 1'b0;
        #13;
        forever #50 tmr_clk = ~tmr_clk;
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_now(input logic [31:0] v, input string tag);
        int n = 0;
        while (now_us != v && n < 5000) begin
            tick_clk(1);
            n++;
        end
        if (now_us != v) chk(1'b0, tag, now_us, v);
    endtask

    task automatic write_cmp(input logic [31:0] v);
        @(posedge clk); #1;
        wr = 1'b1; wdata = v;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    // R3 / R4 monitors
    logic [31:0] prev0;
    logic [7:0]  prev1;
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (!(now_us == prev0 || now_us == prev0 + 1)) tear0++;
            if (!(s_now == prev1 || s_now == prev1 + 8'd1)) tear1++;
            if (prev1 == 8'hff && s_now == 8'h00) saw_wrap = 1;
        end
        prev0 = now_us;
        prev1 = s_now;
    end

    task automatic t_reset;
        rst = 1'b1; wr = 1'b0; wdata = '0;
        tick_clk(300);
        chk(now_us == 0, "R1 count in reset", now_us, 0);
        chk(irq == 0, "R1 irq in reset", irq, 0);
        chk(cmp_rd == 32'hffff_ffff, "R1 compare in reset", cmp_rd, 32'hffff_ffff);
        rst = 1'b0;
        tick_clk(1);
        chk(now_us == 0 && irq == 0 && cmp_rd == 32'hffff_ffff,
            "R1 first cycle after reset", {now_us, 31'd0, irq}, 0);
    endtask

    task automatic t_rate;
        logic [31:0] v;
        int n;
        wait_now(32'd2, "R2 reach 2");
        for (int k = 0; k < 2; k++) begin
            v = now_us; n = 0;
            while (now_us == v && n < 1000) begin tick_clk(1); n++; end
            chk(n >= 249 && n <= 251, "R2 microsecond spacing", n, 250);
        end
    endtask

    task automatic t_match;
        logic [31:0] c;
        int n = 0;
        c = now_us + 3;
        write_cmp(c);
        chk(cmp_rd == c, "R5 readback", cmp_rd, c);
        wait_now(c - 1, "R6 approach");
        tick_clk(100);
        chk(irq == 0, "R6 irq low below compare", irq, 0);
        while (!irq && n < 2000) begin tick_clk(1); n++; end
        tick_clk(5);
        chk(irq == 1 && now_us == c, "R6 irq at compare", now_us, c);
        wait_now(c + 2, "R7 pass compare");
        tick_clk(100);
        chk(irq == 1, "R7 irq held past compare", irq, 1);
    endtask

    task automatic t_stale;
        logic [31:0] c;
        int bad = 0;
        c = now_us + 40;
        write_cmp(c);
        chk(irq == 0, "R8 irq dropped after write", irq, 0);
        for (int k = 0; k < 600; k++) begin
            tick_clk(1);
            if (irq) bad++;
        end
        chk(bad == 0, "R8 no stale re-raise", bad, 0);
    endtask

    task automatic t_prompt;
        logic [31:0] v;
        int n = 0;
        v = now_us;
        while (now_us == v && n < 1000) begin tick_clk(1); n++; end
        tick_clk(5);
        v = now_us;
        write_cmp(v);
        tick_clk(150);
        chk(irq == 1, "R9 compare in force before count moves", irq, 1);
    endtask

    task automatic t_b2b;
        logic [31:0] a, b;
        a = now_us + 3;
        b = now_us + 6;
        @(posedge clk); #1;
        wr = 1'b1; wdata = a;
        @(posedge clk); #1;
        wdata = b;
        @(posedge clk); #1;
        wr = 1'b0;
        chk(cmp_rd == b, "R10 last write wins readback", cmp_rd, b);
        wait_now(a + 1, "R10 pass first value");
        tick_clk(100);
        chk(irq == 0, "R10 first value ignored", irq, 0);
        wait_now(b, "R10 reach second value");
        tick_clk(100);
        chk(irq == 1, "R10 second value matches", irq, 1);
    endtask

    task automatic t_wrap;
        int n = 0;
        while (s_now != 8'hff && n < 80000) begin tick_clk(1); n++; end
        tick_clk(100);
        chk(s_irq == 1, "R11 reset compare fires at all ones", s_irq, 1);
        n = 0;
        while (s_now != 8'h00 && n < 1000) begin tick_clk(1); n++; end
        tick_clk(2);
        chk(saw_wrap, "R4 wrap to zero", s_now, 0);
    endtask

    initial begin
        t_reset;
        t_rate;
        t_match;
        t_stale;
        t_prompt;
        t_b2b;
        t_wrap;
        chk(tear0 == 0, "R3 no torn count (32-bit)", tear0, 0);
        chk(tear1 == 0, "R3 no torn count (8-bit)", tear1, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule